// File: doc/BRIEF.md
# Variable-Width Byte FIFO Port

This block holds the receive and transmit byte queues that sit between a processor register interface and the serial engine of a card host controller. Each queue stores 32 bytes. The processor reaches the receive queue through one read port and the transmit queue through one write port. Each access moves one, two or four bytes. The first byte moved always sits in the most significant lane that the access uses.

On the card side, the serial engine offers one byte per cycle into the receive queue and takes one byte per cycle from the transmit queue. Each side gets an accept indication. Two request flags tell the processor, or a DMA engine, that the queues need service. A discard strobe drops everything queued for transmission, which is how a short final block is flushed out before it fills the queue.

Top module: `vw_byte_fifo`

## Requirements
- R1: Each queue holds up to 32 bytes. Its count output gives the number of stored bytes (0..32, 6 bits). Its full output is high exactly when the count is 32, and its empty output is high exactly when the count is 0.
- R2: `cpu_size` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. In an N-byte read, the oldest byte appears on `cpu_rdata[8N-1:8N-8]`, the next oldest on the lane below it, and so on. `cpu_rdata` is valid in the cycle `cpu_rd` is high, and the bytes leave the queue at that clock edge.
- R3: A read takes only the bytes that are present. Lanes it cannot fill, and all lanes above 8N, read as zero. A read of an empty receive queue returns zero and removes nothing.
- R4: In an N-byte write, `cpu_wdata[8N-1:8N-8]` enters the transmit queue first, followed by the lower lanes in descending order.
- R5: A write stops when the transmit queue reaches 32 bytes. The remaining bytes of that access are dropped, and the bytes already queued are unchanged.
- R6: A card push is refused while the receive queue is full. `card_rx_ok` is low and nothing is stored. A card pop is refused while the transmit queue is empty. `card_tx_ok` is low and the count stays at 0.
- R7: `rx_req` is set by every accepted card push and cleared by every processor read. When both happen in the same cycle, the flag stays set.
- R8: `tx_req` is set by every accepted card pop and cleared by every processor write. When both happen in the same cycle, the flag stays set.
- R9: `tx_discard` empties the transmit queue at the next edge. A processor write in the same cycle is dropped. A card pop in the same cycle is refused (`card_tx_ok` low).
- R10: An active-low reset empties both queues and clears both request flags.
- R11: Byte order is kept when the read and write positions wrap past the end of the 32-byte storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_size | input | 2 | Access width code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| cpu_rd | input | 1 | Processor read of the receive data port |
| cpu_rdata | output | 32 | Packed read data, valid while cpu_rd is high |
| cpu_wr | input | 1 | Processor write of the transmit data port |
| cpu_wdata | input | 32 | Write data, right-aligned to the access width |
| tx_discard | input | 1 | Drop all bytes queued for transmission |
| card_rx_push | input | 1 | Card side offers a received byte |
| card_rx_data | input | 8 | Received byte |
| card_rx_ok | output | 1 | Offered byte is accepted this cycle |
| card_tx_pop | input | 1 | Card side asks for the next byte to send |
| card_tx_data | output | 8 | Byte at the head of the transmit queue |
| card_tx_ok | output | 1 | Pop is accepted this cycle |
| rx_req | output | 1 | Receive service request flag |
| tx_req | output | 1 | Transmit service request flag |
| rx_full | output | 1 | Receive queue holds 32 bytes |
| rx_empty | output | 1 | Receive queue holds no bytes |
| rx_count | output | 6 | Bytes in the receive queue |
| tx_full | output | 1 | Transmit queue holds 32 bytes |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| tx_count | output | 6 | Bytes in the transmit queue |

## Verification
A wrong pointer or count shows up in the cycle after the bad update. Either the count output is off, or the next read or pop returns a byte out of order. Filling a queue across the wrap point makes a miscounted position appear within one pass of 32 bytes. A misplaced lane appears on the same read as a byte in the wrong position, or as a nonzero value in a lane that should be zero. A wrong flag priority is visible one cycle after a coinciding push and read.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int NW     = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  function automatic logic [NW-1:0] lanes_of(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_BYTE: lanes_of = NW'(1);
      SZ_HALF: lanes_of = NW'(2);
      default: lanes_of = NW'(4);
    endcase
  endfunction
endpackage

// File: rtl/bfp_ring.sv
module bfp_ring
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [NW-1:0]               push_n,
  input  logic [LANES-1:0][BYTE_W-1:0] push_data,
  input  logic [NW-1:0]               pop_n,
  output logic [LANES-1:0][BYTE_W-1:0] peek,
  output logic [CW-1:0]               count
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear) begin
      wr_d  = wr_q;
      rd_d  = wr_q;
      cnt_d = '0;
    end else begin
      wr_d  = wr_q + PW'(push_n);
      rd_d  = rd_q + PW'(pop_n);
      cnt_d = cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!clear && (NW'(i) < push_n)) mem[wr_q + PW'(i)] <= push_data[i];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) peek[i] = mem[rd_q + PW'(i)];
  end

  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (32'(cnt_q) + 32'(push_n)) <= (32'(DEPTH) + 32'(pop_n))); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> CW'(pop_n) <= cnt_q); // R3
endmodule

// File: rtl/bfp_req_flag.sv
module bfp_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (clr) q_d = 1'b0;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R7
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q); // R8
endmodule

// File: rtl/vw_byte_fifo.sv
module vw_byte_fifo
  import bfp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cpu_size,
  input  logic             cpu_rd,
  output logic [31:0]      cpu_rdata,
  input  logic             cpu_wr,
  input  logic [31:0]      cpu_wdata,
  input  logic             tx_discard,
  input  logic             card_rx_push,
  input  logic [7:0]       card_rx_data,
  output logic             card_rx_ok,
  input  logic             card_tx_pop,
  output logic [7:0]       card_tx_data,
  output logic             card_tx_ok,
  output logic             rx_req,
  output logic             tx_req,
  output logic             rx_full,
  output logic             rx_empty,
  output logic [CNT_W-1:0] rx_count,
  output logic             tx_full,
  output logic             tx_empty,
  output logic [CNT_W-1:0] tx_count
);
  logic [NW-1:0] nb;
  logic [NW-1:0] rx_push_n, rx_pop_n, tx_push_n, tx_pop_n;
  logic [LANES-1:0][BYTE_W-1:0] rx_in, rx_peek, tx_in, tx_peek;
  logic [CNT_W-1:0] tx_space;
  logic rx_take_ok, tx_give_ok;

  assign nb = lanes_of(cpu_size);

  // receive side
  assign rx_full    = (rx_count == CNT_W'(DEPTH));
  assign rx_empty   = (rx_count == '0);
  assign rx_take_ok = card_rx_push && !rx_full;
  assign card_rx_ok = !rx_full;
  assign rx_push_n  = rx_take_ok ? NW'(1) : '0;

  always_comb begin
    rx_in    = '0;
    rx_in[0] = card_rx_data;
    rx_pop_n = '0;
    if (cpu_rd) rx_pop_n = (CNT_W'(nb) > rx_count) ? NW'(rx_count) : nb;
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (NW'(i) < rx_pop_n) cpu_rdata[(int'(nb) - 1 - i) * 8 +: 8] = rx_peek[i];
    end
  end

  bfp_ring #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(1'b0),
    .push_n(rx_push_n), .push_data(rx_in), .pop_n(rx_pop_n),
    .peek(rx_peek), .count(rx_count)
  );

  // transmit side
  assign tx_full    = (tx_count == CNT_W'(DEPTH));
  assign tx_empty   = (tx_count == '0);
  assign tx_space   = CNT_W'(DEPTH) - tx_count;
  assign tx_give_ok = card_tx_pop && !tx_empty && !tx_discard;
  assign card_tx_ok = !tx_empty && !tx_discard;
  assign card_tx_data = tx_peek[0];
  assign tx_pop_n   = tx_give_ok ? NW'(1) : '0;

  always_comb begin
    tx_in     = '0;
    tx_push_n = '0;
    if (cpu_wr && !tx_discard) tx_push_n = (CNT_W'(nb) > tx_space) ? NW'(tx_space) : nb;
    for (int i = 0; i < LANES; i++) begin
      if (NW'(i) < nb) tx_in[i] = cpu_wdata[(int'(nb) - 1 - i) * 8 +: 8];
    end
  end

  bfp_ring #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(tx_discard),
    .push_n(tx_push_n), .push_data(tx_in), .pop_n(tx_pop_n),
    .peek(tx_peek), .count(tx_count)
  );

  // request flags
  bfp_req_flag u_rxf (.clk(clk), .rst_n(rst_n), .set(rx_take_ok), .clr(cpu_rd), .q(rx_req));
  bfp_req_flag u_txf (.clk(clk), .rst_n(rst_n), .set(tx_give_ok), .clr(cpu_wr), .q(tx_req));

  AST_RXREQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> $past(card_rx_push && card_rx_ok)); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !(card_rx_push && card_rx_ok)) |=> !rx_req); // R7
  AST_TXPOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_ok |-> !tx_empty); // R6
  AST_DROP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_discard |=> tx_empty); // R9
  AST_RX_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !cpu_rd) |=> rx_full); // R6
endmodule

// File: tb/sim_vw_byte_fifo.sv
module sim_vw_byte_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cpu_size = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, tx_discard = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic card_rx_push = 1'b0, card_tx_pop = 1'b0;
  logic [7:0] card_rx_data = '0;
  logic [31:0] cpu_rdata;
  logic card_rx_ok, card_tx_ok, rx_req, tx_req, rx_full, rx_empty, tx_full, tx_empty;
  logic [7:0] card_tx_data;
  logic [5:0] rx_count, tx_count;

  int checks = 0, errors = 0;
  byte unsigned exp_rx[$];
  byte unsigned exp_tx[$];

  always #2 clk = ~clk;

  vw_byte_fifo u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanes(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  // driver: card pushes a byte, expected contents track accepts
  task automatic card_push(byte unsigned b, logic exp_ok);
    @(negedge clk);
    card_rx_push = 1'b1; card_rx_data = b;
    #1 chk("R6 rx accept", card_rx_ok, exp_ok);
    if (exp_ok) exp_rx.push_back(b);
    @(negedge clk);
    card_rx_push = 1'b0;
  endtask

  // monitor side of the read queue: compare packed data against the queue
  task automatic cpu_read(int code, string req);
    logic [31:0] e;
    int n;
    n = lanes(code);
    e = '0;
    @(negedge clk);
    cpu_rd = 1'b1; cpu_size = 2'(code);
    #1;
    for (int i = 0; i < n; i++)
      if (exp_rx.size() > 0) e[8*(n-1-i) +: 8] = exp_rx.pop_front();
    chk(req, cpu_rdata, e);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(int code, logic [31:0] d);
    int n;
    n = lanes(code);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_size = 2'(code); cpu_wdata = d;
    for (int i = 0; i < n; i++)
      if (exp_tx.size() < 32) exp_tx.push_back(d[8*(n-1-i) +: 8]);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic card_pop(string req);
    @(negedge clk);
    card_tx_pop = 1'b1;
    #1;
    if (exp_tx.size() > 0) begin
      chk(req, card_tx_ok, 1'b1);
      chk(req, card_tx_data, exp_tx.pop_front());
    end else chk(req, card_tx_ok, 1'b0);
    @(negedge clk);
    card_tx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rx_empty", rx_empty, 1'b1);
    chk("R10 tx_empty", tx_empty, 1'b1);
    chk("R10 flags", {rx_req, tx_req}, 2'b00);
    chk("R1 counts", {rx_count, tx_count}, 12'd0);
    rst_n = 1'b1;

    // R2 / R3 / R7: basic packing and flags
    card_push(8'h11, 1'b1); card_push(8'h22, 1'b1); card_push(8'h33, 1'b1);
    chk("R7 rx_req set", rx_req, 1'b1);
    chk("R1 rx_count 3", rx_count, 6'd3);
    cpu_read(1, "R2 half read");
    chk("R7 rx_req cleared", rx_req, 1'b0);
    cpu_read(2, "R3 short word read");
    chk("R3 emptied", rx_empty, 1'b1);
    cpu_read(0, "R3 empty read");

    // R11 wrap, R1 full, R6 refuse
    for (int i = 0; i < 32; i++) card_push(8'(8'h40 + i), 1'b1);
    chk("R1 rx_full", rx_full, 1'b1);
    chk("R1 rx_count 32", rx_count, 6'd32);
    card_push(8'hEE, 1'b0);
    chk("R6 count unchanged", rx_count, 6'd32);
    for (int i = 0; i < 8; i++) cpu_read(2, "R11 wrapped word read");
    chk("R1 rx_empty after drain", rx_empty, 1'b1);

    // R7 same-cycle push and read keeps flag set
    card_push(8'h5A, 1'b1);
    @(negedge clk);
    card_rx_push = 1'b1; card_rx_data = 8'h6B; cpu_rd = 1'b1; cpu_size = 2'd0;
    #1 chk("R2 byte read", cpu_rdata, 32'h0000_005A);
    void'(exp_rx.pop_front()); exp_rx.push_back(8'h6B);
    @(negedge clk);
    card_rx_push = 1'b0; cpu_rd = 1'b0;
    chk("R7 set wins", rx_req, 1'b1);
    cpu_read(3, "R3 size3 word read");

    // R4 write ordering, R6 empty pop, R8 flag
    card_pop("R6 pop empty");
    chk("R8 no req on refused pop", tx_req, 1'b0);
    cpu_write(2, 32'hA1B2_C3D4);
    cpu_write(1, 32'h1234_5678);
    cpu_write(0, 32'hFFFF_FF9C);
    chk("R1 tx_count 7", tx_count, 6'd7);
    card_pop("R4 order");
    chk("R8 tx_req set", tx_req, 1'b1);
    for (int i = 0; i < 6; i++) card_pop("R4 order");
    cpu_write(0, 32'h0000_0001);
    chk("R8 tx_req cleared", tx_req, 1'b0);
    card_pop("R4 order");

    // R5 fill stops at 32
    for (int i = 0; i < 7; i++) cpu_write(2, 32'h0102_0304 + 32'(i) * 32'h1010_1010);
    cpu_write(1, 32'h0000_7788);
    cpu_write(2, 32'hAABB_CCDD);
    chk("R5 tx_full", tx_full, 1'b1);
    chk("R5 tx_count 32", tx_count, 6'd32);
    cpu_write(2, 32'h1111_1111);
    for (int i = 0; i < 32; i++) card_pop("R5 R11 tx data");
    chk("R1 tx_empty", tx_empty, 1'b1);

    // R9 discard
    cpu_write(2, 32'hDEAD_BEEF);
    @(negedge clk);
    tx_discard = 1'b1; card_tx_pop = 1'b1; cpu_wr = 1'b1; cpu_size = 2'd2; cpu_wdata = 32'h5555_5555;
    #1 chk("R9 pop refused", card_tx_ok, 1'b0);
    @(negedge clk);
    tx_discard = 1'b0; card_tx_pop = 1'b0; cpu_wr = 1'b0;
    exp_tx.delete();
    chk("R9 tx emptied", tx_count, 6'd0);
    cpu_write(0, 32'h0000_0042);
    card_pop("R9 new data after discard");

    // R10 reset mid-run
    card_push(8'h77, 1'b1);
    cpu_write(2, 32'h0A0B_0C0D);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 rx cleared", rx_count, 6'd0);
    chk("R10 tx cleared", tx_count, 6'd0);
    chk("R10 rx_req cleared", rx_req, 1'b0);
    exp_rx.delete(); exp_tx.delete();
    @(negedge clk);
    rst_n = 1'b1;
    cpu_read(0, "R10 empty after reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule